// File: doc/BRIEF.md
# Routed Interrupt Controller

This block collects level-sensitive interrupt requests from peripherals and presents them to a processor on two lines: a normal interrupt line and a fast interrupt line. Each source is sampled into a raw pending register every clock, gated by a per-source enable bit, and steered to one of the two lines by a per-source route bit. Software reads a filtered status view for each line and, for each line, a register that names the lowest-numbered source pending on it.

The base bank serves 32 sources. A parameter adds a second bank for sources 32 to 63 with its own raw, enable, route and filtered status registers, plus a one-bit error-priority enable. When that bank is left out, its offsets read as zero and writes to them are dropped. Register access uses a plain single-cycle port: a write takes effect at the clock edge where `wr_en` is high, and a read returns data combinationally from the addressed register.

Top module: `intc_route`

## Requirements
- R1: After reset, the enable and route registers of both banks read zero, both interrupt outputs are low, and both lowest-pending registers read 0x3F.
- R2: The raw registers (offset 0x00 for sources 0-31, 0x20 for sources 32-63) show the source levels sampled at the previous clock edge, whatever the enable and route settings.
- R3: The enable registers (0x04 lower, 0x24 upper) are read/write; the normal-line status registers (0x0C lower, 0x2C upper) read raw AND enable AND NOT route, so a zero enable word masks every source.
- R4: The route registers (0x08 lower, 0x28 upper) are read/write, a 1 sending that source to the fast line; the fast-line status registers (0x10 lower, 0x30 upper) read raw AND enable AND route.
- R5: `irq_o` is high exactly when any normal-line status bit of either bank is set, and `fiq_o` exactly when any fast-line status bit is set.
- R6: Offset 0x18 returns, in bits 5:0 with all higher bits zero, the index of the lowest-numbered set normal-line status bit over all sources, or 0x3F when none is set.
- R7: Offset 0x1C returns the same encoding for the fast-line status bits.
- R8: Writes to the read-only offsets (0x00, 0x0C, 0x10, 0x18, 0x1C, 0x20, 0x2C, 0x30) change no register and no output.
- R9: Offset 0x14 is a 32-bit read/write word and offset 0x34 holds a read/write bit in bit 0 (other bits read zero); neither changes the status views, the lowest-pending codes or the outputs.
- R10: With the upper bank disabled, offsets 0x20 to 0x34 read zero, writes to them are dropped, and only sources 0-31 exist.
- R11: Offsets 0x38 and 0x3C, and any address whose two low bits are not zero, read zero and take no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NSRC | Level-sensitive interrupt requests, 64 with the upper bank, 32 without |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the addressed register |
| irq_o | output | 1 | Normal interrupt line to the processor |
| fiq_o | output | 1 | Fast interrupt line to the processor |

## Verification
A walking single source over all 64 positions with odd sources routed fast shows that each source reaches the right raw bit, the right line and the right lowest-pending code, which separates a bank or index error from a routing error. Pseudo-random mixes of source, enable and route words with several bits set at once check the masking equations and that the encoder picks the lowest index rather than any set one. An all-sources-high, all-masked pattern and writes aimed at read-only and spare words show that masking and write decode hold, and a second instance without the upper bank shows those offsets read zero and upper sources never reach the outputs.

// File: rtl/intc_pkg.sv
package intc_pkg;

   // Word index = byte offset / 4 of each register
   typedef enum logic [3:0] {
      W_RAW_LO  = 4'd0,
      W_EN_LO   = 4'd1,
      W_RTE_LO  = 4'd2,
      W_NRM_LO  = 4'd3,
      W_FST_LO  = 4'd4,
      W_PRIO    = 4'd5,
      W_NRM_TOP = 4'd6,
      W_FST_TOP = 4'd7,
      W_RAW_HI  = 4'd8,
      W_EN_HI   = 4'd9,
      W_RTE_HI  = 4'd10,
      W_NRM_HI  = 4'd11,
      W_FST_HI  = 4'd12,
      W_ERR_EN  = 4'd13,
      W_SPARE0  = 4'd14,
      W_SPARE1  = 4'd15
   } intc_word_e;

   localparam int WIN_BITS = 6;

endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src_i,
   input  logic         en_we,
   input  logic         rte_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] raw_q,
   output logic [W-1:0] en_q,
   output logic [W-1:0] rte_q,
   output logic [W-1:0] nrm_st,
   output logic [W-1:0] fst_st
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
         en_q  <= '0;
         rte_q <= '0;
      end else begin
         raw_q <= src_i;
         if (en_we)  en_q  <= wdata;
         if (rte_we) rte_q <= wdata;
      end
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign nrm_st[b] = raw_q[b] & en_q[b] & ~rte_q[b];
      assign fst_st[b] = raw_q[b] & en_q[b] &  rte_q[b];
   end

endmodule

// File: rtl/intc_first_set.sv
module intc_first_set #(
   parameter  int W  = 64,
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx
);

   always_comb begin
      idx = '1;
      for (int k = W - 1; k >= 0; k--) begin
         if (vec[k]) idx = IW'(k);
      end
   end

endmodule

// File: rtl/intc_route.sv
module intc_route #(
   parameter  int DATA_W     = 32,
   parameter  bit UPPER_BANK = 1'b1,
   parameter  int ADDR_W     = 6,
   localparam int NSRC       = UPPER_BANK ? 2 * DATA_W : DATA_W,
   localparam int ALL_W      = 2 * DATA_W,
   localparam int IDX_W      = $clog2(ALL_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_i,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_o,
   output logic              fiq_o
);
   import intc_pkg::*;

   if (DATA_W != 32) begin : g_bad_width
      $error("intc_route: DATA_W must be 32");
   end
   if (ADDR_W < WIN_BITS) begin : g_bad_addr
      $error("intc_route: ADDR_W must cover the 64-byte window");
   end

   logic        hit;
   intc_word_e  word;

   assign hit  = (addr[1:0] == 2'b00) && ((addr >> WIN_BITS) == '0);
   assign word = intc_word_e'(addr[5:2]);

   logic wr_hit;
   assign wr_hit = wr_en & hit;

   // lower bank
   logic [DATA_W-1:0] raw_lo, en_lo, rte_lo, nrm_lo, fst_lo;

   intc_bank #(.W(DATA_W)) u_bank_lo (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i[DATA_W-1:0]),
      .en_we  (wr_hit && word == W_EN_LO),
      .rte_we (wr_hit && word == W_RTE_LO),
      .wdata  (wdata),
      .raw_q  (raw_lo),
      .en_q   (en_lo),
      .rte_q  (rte_lo),
      .nrm_st (nrm_lo),
      .fst_st (fst_lo)
   );

   // free-use priority word
   logic [DATA_W-1:0] prio_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        prio_q <= '0;
      else if (wr_hit && word == W_PRIO) prio_q <= wdata;
   end

   // upper bank, present or tied off
   logic [DATA_W-1:0] raw_hi, en_hi, rte_hi, nrm_hi, fst_hi;
   logic              err_en_q;

   if (UPPER_BANK) begin : g_hi
      intc_bank #(.W(DATA_W)) u_bank_hi (
         .clk    (clk),
         .rst_n  (rst_n),
         .src_i  (src_i[NSRC-1:DATA_W]),
         .en_we  (wr_hit && word == W_EN_HI),
         .rte_we (wr_hit && word == W_RTE_HI),
         .wdata  (wdata),
         .raw_q  (raw_hi),
         .en_q   (en_hi),
         .rte_q  (rte_hi),
         .nrm_st (nrm_hi),
         .fst_st (fst_hi)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          err_en_q <= 1'b0;
         else if (wr_hit && word == W_ERR_EN) err_en_q <= wdata[0];
      end
   end else begin : g_no_hi
      assign raw_hi   = '0;
      assign en_hi    = '0;
      assign rte_hi   = '0;
      assign nrm_hi   = '0;
      assign fst_hi   = '0;
      assign err_en_q = 1'b0;
   end

   // line outputs and lowest-pending encoders
   logic [ALL_W-1:0] nrm_all, fst_all;
   logic [IDX_W-1:0] nrm_idx, fst_idx;

   assign nrm_all = {nrm_hi, nrm_lo};
   assign fst_all = {fst_hi, fst_lo};
   assign irq_o   = |nrm_all;
   assign fiq_o   = |fst_all;

   intc_first_set #(.W(ALL_W)) u_nrm_enc (.vec(nrm_all), .idx(nrm_idx));
   intc_first_set #(.W(ALL_W)) u_fst_enc (.vec(fst_all), .idx(fst_idx));

   // read mux
   always_comb begin
      rdata = '0;
      if (hit) begin
         case (word)
            W_RAW_LO:  rdata = raw_lo;
            W_EN_LO:   rdata = en_lo;
            W_RTE_LO:  rdata = rte_lo;
            W_NRM_LO:  rdata = nrm_lo;
            W_FST_LO:  rdata = fst_lo;
            W_PRIO:    rdata = prio_q;
            W_NRM_TOP: rdata = DATA_W'(nrm_idx);
            W_FST_TOP: rdata = DATA_W'(fst_idx);
            W_RAW_HI:  rdata = raw_hi;
            W_EN_HI:   rdata = en_hi;
            W_RTE_HI:  rdata = rte_hi;
            W_NRM_HI:  rdata = nrm_hi;
            W_FST_HI:  rdata = fst_hi;
            W_ERR_EN:  rdata = DATA_W'(err_en_q);
            default:   rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/intc_route_chk.sv
module intc_route_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6,
   parameter int NSRC   = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSRC-1:0]   src_i,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] rdata,
   input logic              irq_o,
   input logic              fiq_o
);

   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!irq_o && !fiq_o));

   a_r2_raw_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && addr == ADDR_W'(8'h00)) |-> rdata == $past(src_i[DATA_W-1:0]));

   a_r5_irq_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(|src_i));

   a_r5_fiq_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> $past(|src_i));

   a_r6_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && addr == ADDR_W'(8'h18)) |-> rdata == DATA_W'(8'h3F));

   a_r7_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      (!fiq_o && addr == ADDR_W'(8'h1C)) |-> rdata == DATA_W'(8'h3F));

   a_r6_code_width: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(8'h18)) |-> rdata[DATA_W-1:6] == '0);

   a_r11_unaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr[1:0] != 2'b00) |-> rdata == '0);

endmodule

bind intc_route intc_route_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NSRC(NSRC)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .src_i (src_i),
   .addr  (addr),
   .rdata (rdata),
   .irq_o (irq_o),
   .fiq_o (fiq_o)
);

// File: tb/intc_route_tb.sv
`timescale 1ns/1ps
module intc_route_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src = '0;
   logic        wr_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, rdata_lo;
   logic        irq_o, fiq_o, irq_lo, fiq_lo;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   intc_route #(.DATA_W(32), .UPPER_BANK(1'b1), .ADDR_W(6)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o));

   intc_route #(.DATA_W(32), .UPPER_BANK(1'b0), .ADDR_W(6)) u_dut_lo (
      .clk(clk), .rst_n(rst_n), .src_i(src[31:0]), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata_lo), .irq_o(irq_lo), .fiq_o(fiq_lo));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic rd_lo(input logic [5:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata_lo;
   endtask

   task automatic drive(input logic [63:0] v);
      @(negedge clk);
      src = v;
      @(negedge clk);
   endtask

   function automatic logic [31:0] lowest(input logic [63:0] v);
      logic [31:0] r = 32'h3F;
      for (int k = 63; k >= 0; k--) if (v[k]) r = k;
      return r;
   endfunction

   function automatic logic [63:0] step(input logic [63:0] s);
      logic [63:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, dl;
      logic [63:0] s, v, en, sel, en_nrm, en_fst;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(6'h04, d); chk("R1 enable lo", d, 0);
      rd(6'h08, d); chk("R1 route lo", d, 0);
      rd(6'h24, d); chk("R1 enable hi", d, 0);
      rd(6'h28, d); chk("R1 route hi", d, 0);
      rd(6'h18, d); chk("R1 nrm code", d, 32'h3F);
      rd(6'h1C, d); chk("R1 fst code", d, 32'h3F);
      chk("R1 outputs", {irq_o, fiq_o}, 0);

      // R3 R4 register readback
      wr(6'h04, 32'hFFFF_FFFF); wr(6'h24, 32'hFFFF_FFFF);
      wr(6'h08, 32'hAAAA_AAAA); wr(6'h28, 32'hAAAA_AAAA);
      rd(6'h04, d); chk("R3 enable lo rb", d, 32'hFFFF_FFFF);
      rd(6'h28, d); chk("R4 route hi rb", d, 32'hAAAA_AAAA);

      // R11 spare and unaligned
      rd(6'h38, d); chk("R11 spare 0x38", d, 0);
      rd(6'h3C, d); chk("R11 spare 0x3C", d, 0);
      rd(6'h05, d); chk("R11 unaligned", d, 0);
      wr(6'h09, 32'h0);
      rd(6'h08, d); chk("R11 unaligned write dropped", d, 32'hAAAA_AAAA);

      // walking source: odd sources go to the fast line
      for (int i = 0; i < 64; i++) begin
         v = 64'd1 << i;
         drive(v);
         rd(i < 32 ? 6'h00 : 6'h20, d);
         chk("R2 raw walk", d, i < 32 ? v[31:0] : v[63:32]);
         chk("R5 irq walk", irq_o, (i % 2) == 0);
         chk("R5 fiq walk", fiq_o, (i % 2) == 1);
         rd(6'h18, d); chk("R6 nrm code walk", d, (i % 2) == 0 ? i : 32'h3F);
         rd(6'h1C, d); chk("R7 fst code walk", d, (i % 2) == 1 ? i : 32'h3F);
      end

      // pseudo-random mixes
      s = 64'h1234_5678_9ABC_DEF1;
      for (int n = 0; n < 48; n++) begin
         s = step(s); v = s;
         s = step(s); en = s;
         s = step(s); sel = s;
         wr(6'h04, en[31:0]);  wr(6'h24, en[63:32]);
         wr(6'h08, sel[31:0]); wr(6'h28, sel[63:32]);
         drive(v);
         en_nrm = v & en & ~sel;
         en_fst = v & en & sel;
         rd(6'h0C, d); chk("R3 nrm lo mix", d, en_nrm[31:0]);
         rd(6'h2C, d); chk("R3 nrm hi mix", d, en_nrm[63:32]);
         rd(6'h10, d); chk("R4 fst lo mix", d, en_fst[31:0]);
         rd(6'h30, d); chk("R4 fst hi mix", d, en_fst[63:32]);
         chk("R5 irq mix", irq_o, |en_nrm);
         chk("R5 fiq mix", fiq_o, |en_fst);
         rd(6'h18, d); chk("R6 nrm code mix", d, lowest(en_nrm));
         rd(6'h1C, d); chk("R7 fst code mix", d, lowest(en_fst));
      end

      // R3 everything masked
      wr(6'h04, 0); wr(6'h24, 0);
      drive('1);
      chk("R3 masked outputs", {irq_o, fiq_o}, 0);
      rd(6'h0C, d); chk("R3 masked nrm", d, 0);
      rd(6'h18, d); chk("R3 masked code", d, 32'h3F);
      rd(6'h20, d); chk("R2 raw hi all", d, 32'hFFFF_FFFF);

      // R8 writes to read-only words
      wr(6'h04, 32'hFFFF_FFFF); wr(6'h24, 32'hFFFF_FFFF);
      wr(6'h08, 0); wr(6'h28, 0);
      drive(64'h5);
      wr(6'h00, 32'hFFFF_FFFF); wr(6'h0C, 0); wr(6'h10, 32'hFFFF_FFFF);
      wr(6'h18, 32'h7); wr(6'h1C, 0); wr(6'h20, 32'hFFFF_FFFF);
      wr(6'h2C, 32'hFFFF_FFFF); wr(6'h30, 32'hFFFF_FFFF);
      rd(6'h00, d); chk("R8 raw lo kept", d, 32'h5);
      rd(6'h0C, d); chk("R8 nrm kept", d, 32'h5);
      rd(6'h18, d); chk("R8 code kept", d, 0);
      rd(6'h20, d); chk("R8 raw hi kept", d, 0);
      rd(6'h30, d); chk("R8 fst hi kept", d, 0);
      chk("R8 outputs", {irq_o, fiq_o}, 2'b10);

      // R9 priority and error-enable words
      wr(6'h14, 32'hDEAD_BEEF);
      rd(6'h14, d); chk("R9 prio rb", d, 32'hDEAD_BEEF);
      wr(6'h34, 32'hFFFF_FFFF);
      rd(6'h34, d); chk("R9 err bit rb", d, 1);
      rd(6'h18, d); chk("R9 code unchanged", d, 0);
      rd(6'h0C, d); chk("R9 nrm unchanged", d, 32'h5);
      chk("R9 outputs", {irq_o, fiq_o}, 2'b10);

      // R10 instance without the upper bank
      rd_lo(6'h0C, dl); chk("R10 lo nrm works", dl, 32'h5);
      rd_lo(6'h24, dl); chk("R10 enable hi zero", dl, 0);
      rd_lo(6'h20, dl); chk("R10 raw hi zero", dl, 0);
      rd_lo(6'h28, dl); chk("R10 route hi zero", dl, 0);
      rd_lo(6'h2C, dl); chk("R10 nrm hi zero", dl, 0);
      rd_lo(6'h30, dl); chk("R10 fst hi zero", dl, 0);
      rd_lo(6'h34, dl); chk("R10 err zero", dl, 0);
      drive(64'd1 << 40);
      chk("R10 upper src ignored", {irq_lo, fiq_lo}, 0);
      rd_lo(6'h18, dl); chk("R10 code idle", dl, 32'h3F);
      chk("R5 full irq upper", irq_o, 1'b1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule